// File: doc/BRIEF.md
# Synchronous serial status flag controller

This block keeps the five status flags of a clock-synchronous serial port: transmit buffer empty, transmit finished, receive buffer full, receive overrun and chip-select conflict. The shift engine reports events to it as one-cycle strobes: a byte was received, the transmit buffer moved into the shift register, the last transmit bit ended, and a transfer started. It also watches the chip-select input level. The bus side sends its own strobes: a read or write of the status register, a read of the receive buffer, a write of the transmit buffer, and the clearing of transmit enable.

Software clears a flag in two steps. First it reads the register and sees the flag as 1. Then it writes 0 to that bit. Each flag keeps a private "observed set" bit. A write of 1 cancels that bit, and so does a fresh hardware set of the flag. While the overrun flag is set, an inhibit output tells the shift engine not to start new transfers.

Top module: `ssi_status_ctrl`

## Requirements
- R1: After reset the status register reads 00h and `xfer_inhibit` is 0.
- R2: Register bits 4, 3 and 1 always read 0. Writing 1 to them changes nothing.
- R3: A register write clears a flag to 0 when the written bit is 0 and an earlier register read returned that flag as 1. If no such read happened, the write has no effect. Flag positions: bit 7 transmit-empty, bit 6 transmit-end, bit 5 receive-full, bit 2 overrun, bit 0 conflict.
- R4: Writing 1 to a flag bit cancels that flag's earlier read. A later write of 0 then leaves the flag at 1.
- R5: A hardware set of a flag after it was read cancels that read. A later write of 0 then leaves the flag at 1.
- R6: When a hardware set and a clear of the same flag come in the same cycle, the flag ends up 1.
- R7: In four-wire master mode, `xfer_start` with `cs_n` low sets the conflict flag. With `cs_n` high it does not.
- R8: In four-wire slave mode, a low-to-high change of `cs_n` while `xfer_active` is 1 sets the conflict flag. The same change in master mode or in three-wire mode does not set it.
- R9: `rx_done` sets receive-full. `rx_done` while receive-full is already 1 also sets overrun and leaves receive-full at 1. `rx_buf_rd` clears receive-full.
- R10: `xfer_inhibit` is 1 exactly while the overrun flag is 1.
- R11: `tx_buf_wr` clears both transmit-end and transmit-empty. `tx_load` sets transmit-empty, and so does `tx_en_clr`.
- R12: `tx_bit_end` sets transmit-end only when transmit-empty is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| four_wire | input | 1 | 1 selects four-wire mode with chip-select |
| is_master | input | 1 | 1 when the port is the master |
| cs_n | input | 1 | Chip-select input level, already synchronized |
| xfer_start | input | 1 | Strobe: a transfer begins |
| xfer_active | input | 1 | A transfer is in progress |
| rx_done | input | 1 | Strobe: a receive completed |
| tx_load | input | 1 | Strobe: transmit buffer moved to shifter |
| tx_bit_end | input | 1 | Strobe: last transmit bit ended |
| reg_rd | input | 1 | Strobe: status register read |
| reg_wr | input | 1 | Strobe: status register write |
| wr_data | input | REG_W | Status register write data |
| rx_buf_rd | input | 1 | Strobe: receive buffer read |
| tx_buf_wr | input | 1 | Strobe: transmit buffer write |
| tx_en_clr | input | 1 | Strobe: transmit enable cleared |
| status_q | output | REG_W | Status register read value |
| xfer_inhibit | output | 1 | Blocks transfer starts while overrun is set |

## Verification
The bench uses the default `REG_W` of 8, which is the only width at which the fixed flag positions fill the register. This lets a single write byte of FFh or FBh reach every assigned flag and every unassigned bit together, so the handshake and the unassigned-bit masking are exercised through the same register write. A table walk covers the receive, transmit and handshake paths. Directed runs cover the three mode combinations of chip-select, the set-versus-clear collision, and a reset asserted in the middle of a run.

// File: rtl/ssi_status_pkg.sv
package ssi_status_pkg;
  localparam int unsigned NUM_FLAGS = 5;

  typedef enum logic [2:0] {
    FL_CONFLICT = 3'd0,
    FL_OVERRUN  = 3'd1,
    FL_RX_FULL  = 3'd2,
    FL_TX_END   = 3'd3,
    FL_TX_EMPTY = 3'd4
  } flag_idx_e;

  // Bit positions inside the software-visible register (decoded by drivers)
  localparam int unsigned FLAG_POS [NUM_FLAGS] = '{0, 2, 5, 6, 7};
  localparam int unsigned MAX_POS = 7;
endpackage

// File: rtl/ssi_flag_cell.sv
module ssi_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic reg_rd,
  input  logic reg_wr,
  input  logic wr_bit,
  output logic flag_q
);
  logic seen_q;
  logic flag_d, seen_d;
  logic sw_clr;

  assign sw_clr = reg_wr && !wr_bit && seen_q;

  always_comb begin
    flag_d = flag_q;
    seen_d = seen_q;
    if (reg_rd) seen_d = flag_q;
    if (reg_wr) seen_d = 1'b0;
    if (hw_set) begin
      flag_d = 1'b1;
      seen_d = 1'b0;
    end else if (hw_clr || sw_clr) begin
      flag_d = 1'b0;
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      seen_q <= seen_d;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag_q); // R6

  AST_CLEAR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(hw_clr || reg_wr)); // R3
endmodule

// File: rtl/ssi_event_decode.sv
module ssi_event_decode
  import ssi_status_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 four_wire,
  input  logic                 is_master,
  input  logic                 cs_n,
  input  logic                 xfer_start,
  input  logic                 xfer_active,
  input  logic                 rx_done,
  input  logic                 tx_load,
  input  logic                 tx_bit_end,
  input  logic                 rx_buf_rd,
  input  logic                 tx_buf_wr,
  input  logic                 tx_en_clr,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] set_vec,
  output logic [NUM_FLAGS-1:0] clr_vec
);
  logic cs_prev_q;
  logic cs_rise, master_conf, slave_conf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_prev_q <= 1'b1;
    else        cs_prev_q <= cs_n;
  end

  assign cs_rise     = cs_n && !cs_prev_q;
  assign master_conf = four_wire && is_master && xfer_start && !cs_n;
  assign slave_conf  = four_wire && !is_master && xfer_active && cs_rise;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[FL_CONFLICT] = master_conf || slave_conf;
    set_vec[FL_OVERRUN]  = rx_done && flags[FL_RX_FULL];
    set_vec[FL_RX_FULL]  = rx_done;
    set_vec[FL_TX_END]   = tx_bit_end && flags[FL_TX_EMPTY];
    set_vec[FL_TX_EMPTY] = tx_load || tx_en_clr;
    clr_vec[FL_RX_FULL]  = rx_buf_rd;
    clr_vec[FL_TX_END]   = tx_buf_wr;
    clr_vec[FL_TX_EMPTY] = tx_buf_wr;
  end
endmodule

// File: rtl/ssi_status_ctrl.sv
module ssi_status_ctrl
  import ssi_status_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             four_wire,
  input  logic             is_master,
  input  logic             cs_n,
  input  logic             xfer_start,
  input  logic             xfer_active,
  input  logic             rx_done,
  input  logic             tx_load,
  input  logic             tx_bit_end,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rx_buf_rd,
  input  logic             tx_buf_wr,
  input  logic             tx_en_clr,
  output logic [REG_W-1:0] status_q,
  output logic             xfer_inhibit
);
  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;

  ssi_event_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .four_wire  (four_wire),
    .is_master  (is_master),
    .cs_n       (cs_n),
    .xfer_start (xfer_start),
    .xfer_active(xfer_active),
    .rx_done    (rx_done),
    .tx_load    (tx_load),
    .tx_bit_end (tx_bit_end),
    .rx_buf_rd  (rx_buf_rd),
    .tx_buf_wr  (tx_buf_wr),
    .tx_en_clr  (tx_en_clr),
    .flags      (flags),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    ssi_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .hw_set(set_vec[g]),
      .hw_clr(clr_vec[g]),
      .reg_rd(reg_rd),
      .reg_wr(reg_wr),
      .wr_bit(wr_data[FLAG_POS[g]]),
      .flag_q(flags[g])
    );
  end

  always_comb begin
    status_q = '0;
    for (int i = 0; i < NUM_FLAGS; i++) status_q[FLAG_POS[i]] = flags[i];
  end

  assign xfer_inhibit = flags[FL_OVERRUN];

  initial assert (REG_W > MAX_POS) else $error("REG_W too small for flag positions");

  AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[2]) |-> $past(status_q[5])); // R9

  AST_TX_END_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[6]) |-> $past(status_q[7])); // R12

  AST_TXWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_buf_wr && !tx_load && !tx_en_clr) |=> (!status_q[6] && !status_q[7])); // R11

  AST_MASTER_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    (four_wire && is_master && xfer_start && !cs_n) |=> status_q[0]); // R7

  AST_RX_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && status_q[5]) |=> (status_q[5] && status_q[2])); // R9
endmodule

// File: tb/tb_ssi_status_ctrl.sv
module tb_ssi_status_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic four_wire, is_master, cs_n, xfer_start, xfer_active;
  logic rx_done, tx_load, tx_bit_end, reg_rd, reg_wr;
  logic [7:0] wr_data;
  logic rx_buf_rd, tx_buf_wr, tx_en_clr;
  logic [7:0] status_q;
  logic xfer_inhibit;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ssi_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .four_wire(four_wire), .is_master(is_master),
    .cs_n(cs_n), .xfer_start(xfer_start), .xfer_active(xfer_active),
    .rx_done(rx_done), .tx_load(tx_load), .tx_bit_end(tx_bit_end),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .wr_data(wr_data),
    .rx_buf_rd(rx_buf_rd), .tx_buf_wr(tx_buf_wr), .tx_en_clr(tx_en_clr),
    .status_q(status_q), .xfer_inhibit(xfer_inhibit)
  );

  // {rd,wr,rxd,txl,tbe,rxr,txw,tec}, wdata, expected status, expected inhibit
  localparam int NV = 18;
  localparam logic [24:0] VEC [NV] = '{
    {8'b0010_0000, 8'h00, 8'h20, 1'b0}, // R9 receive sets full
    {8'b0010_0000, 8'h00, 8'h24, 1'b1}, // R9 R10 overrun
    {8'b0100_0000, 8'h00, 8'h24, 1'b1}, // R3 write without read
    {8'b1000_0000, 8'h00, 8'h24, 1'b1}, // R3 read
    {8'b0100_0000, 8'hFB, 8'h20, 1'b0}, // R3 R10 clear overrun
    {8'b0100_0000, 8'h00, 8'h20, 1'b0}, // R4 write 1 cancelled read
    {8'b0000_0100, 8'h00, 8'h00, 1'b0}, // R9 buffer read
    {8'b0001_0000, 8'h00, 8'h80, 1'b0}, // R11 load sets empty
    {8'b0000_1000, 8'h00, 8'hC0, 1'b0}, // R12 bit end
    {8'b0000_0010, 8'h00, 8'h00, 1'b0}, // R11 buffer write
    {8'b0000_1000, 8'h00, 8'h00, 1'b0}, // R12 no empty
    {8'b0000_0001, 8'h00, 8'h80, 1'b0}, // R11 enable cleared
    {8'b0100_0000, 8'hFF, 8'h80, 1'b0}, // R2 unassigned bits
    {8'b1000_0000, 8'h00, 8'h80, 1'b0}, // R5 read
    {8'b0001_0000, 8'h00, 8'h80, 1'b0}, // R5 new set
    {8'b0100_0000, 8'h00, 8'h80, 1'b0}, // R5 write ignored
    {8'b1000_0000, 8'h00, 8'h80, 1'b0}, // R3 read
    {8'b0100_0000, 8'h00, 8'h00, 1'b0}  // R3 clear
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    rx_done = 0; tx_load = 0; tx_bit_end = 0; reg_rd = 0; reg_wr = 0;
    rx_buf_rd = 0; tx_buf_wr = 0; tx_en_clr = 0; xfer_start = 0; wr_data = 8'h00;
  endtask

  task automatic step(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    {reg_rd, reg_wr, rx_done, tx_load, tx_bit_end, rx_buf_rd, tx_buf_wr, tx_en_clr} = c;
    wr_data = d;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0; idle();
    four_wire = 0; is_master = 0; cs_n = 1; xfer_active = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 status", status_q, 8'h00);
    chk("R1 inhibit", {7'd0, xfer_inhibit}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][24:17], VEC[i][16:9]);
      chk($sformatf("vector %0d status", i), status_q, VEC[i][8:1]);
      chk($sformatf("vector %0d inhibit R10", i), {7'd0, xfer_inhibit}, {7'd0, VEC[i][0]});
    end

    // R6: set and software clear together
    step(8'b0001_0000, 8'h00);
    step(8'b1000_0000, 8'h00);
    step(8'b0101_0000, 8'h00);
    chk("R6 set wins", status_q, 8'h80);
    step(8'b0100_0000, 8'h00);
    chk("R6 R5 read cancelled", status_q, 8'h80);
    step(8'b1000_0000, 8'h00);
    step(8'b0100_0000, 8'h00);
    chk("R3 clear empty", status_q, 8'h00);

    // R7: master conflict
    four_wire = 1; is_master = 1; cs_n = 1;
    @(negedge clk); xfer_start = 1; @(negedge clk); xfer_start = 0;
    chk("R7 cs high no conflict", status_q, 8'h00);
    cs_n = 0;
    @(negedge clk); xfer_start = 1; @(negedge clk); xfer_start = 0;
    chk("R7 conflict", status_q, 8'h01);
    cs_n = 1;
    step(8'b1000_0000, 8'h00);
    step(8'b0100_0000, 8'h00);
    chk("R3 clear conflict", status_q, 8'h00);

    // R8: chip-select rise in master mode ignored
    xfer_active = 1; cs_n = 0;
    @(negedge clk); cs_n = 1; @(negedge clk);
    chk("R8 master rise ignored", status_q, 8'h00);
    // three-wire slave ignored
    four_wire = 0; is_master = 0; cs_n = 0;
    @(negedge clk); cs_n = 1; @(negedge clk);
    chk("R8 three-wire ignored", status_q, 8'h00);
    // four-wire slave conflict
    four_wire = 1; cs_n = 0;
    @(negedge clk); cs_n = 1; @(negedge clk);
    chk("R8 slave conflict", status_q, 8'h01);
    xfer_active = 0;

    // R1: reset in mid-run
    step(8'b0010_0000, 8'h00);
    step(8'b0010_0000, 8'h00);
    chk("R10 inhibit before reset", {7'd0, xfer_inhibit}, 8'h01);
    do_reset();
    chk("R1 status after reset", status_q, 8'h00);
    chk("R1 inhibit after reset", {7'd0, xfer_inhibit}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule